// File: doc/BRIEF.md
# Unibus DMA Address Translator and Lane Packer

This block sits between a 16-bit Unibus DMA device and a 36-bit word memory. A DMA device hands it a start byte address, a byte count, a direction and a byte/word mode. The block walks the transfer one element at a time. For each element it turns the Unibus byte address into a memory word address through a page map table, then moves the byte or halfword between the device and its irregular bit position inside the 36-bit word.

Software programs the map table through a small index/write/read port. Each entry holds a valid flag and a page frame number. The word address is the byte address divided by four. Its upper bits pick the map entry and its lower bits give the offset inside the page. The physical word address is the entry's frame number with the offset appended.

A failed translation ends the transfer early, and so does an access beyond the installed memory. The block then pulses the timeout flag together with the done pulse and reports how many bytes were left. Writes are read-modify-write, so that bits outside the written lane survive.

Control is one state machine with four states:
- `ST_IDLE` accepts a request. It goes to `ST_XLATE`, or straight to `ST_DONE` when the effective count is zero.
- `ST_XLATE` translates the current address. It goes to `ST_DATA` and issues a memory read when the translation is good, and goes to `ST_DONE` with the timeout flag set when it is not.
- `ST_DATA` consumes the read word: it delivers the read element, or writes back the merged word. It returns to `ST_XLATE` while bytes remain and goes to `ST_DONE` after the last element.
- `ST_DONE` pulses done and returns to `ST_IDLE`.

Top module: `ubm_dma_map`

## Requirements
- R1: After reset every map entry reads back invalid, `busy` and `done` are low, and a transfer through any entry ends with a timeout.
- R2: A map write to an index sets that entry's valid flag and frame number, which read back combinationally on `map_rvalid`/`map_rpfn` for the same index; clearing the valid flag later makes translations through it fail.
- R3: The word address is the byte address shifted right by 2. Its bits above `PAGE_OFF_W` select the map entry, and the memory address is `{frame, word_address[PAGE_OFF_W-1:0]}`.
- R4: A translation fails when the page index is `MAP_DEPTH` or more, when address bit 17 is set, or when the entry is invalid. The transfer then stops with `tmo` high during the done pulse and `resid` equal to the bytes not transferred; elements before the failure complete normally.
- R5: A translated word address of `MEM_WORDS` or more is treated as nonexistent memory and stops the transfer the same way as R4, with no memory access for that element.
- R6: Byte-mode reads return on `elem_rdata[7:0]` (upper bits zero) the word bits picked by the byte address modulo 4: lane 0 gives bits 25:18, lane 1 gives 33:26, lane 2 gives 7:0, lane 3 gives 15:8.
- R7: Word-mode reads return word bits 15:0 when byte address bit 1 is set and word bits 33:18 when it is clear.
- R8: In word mode the start address has bit 0 forced to zero and the count has bit 0 cleared; a zero effective count completes with done, `resid` 0, no timeout and no memory access.
- R9: A word write with address bit 1 set replaces word bits 15:0 and keeps bits 35:16. With bit 1 clear it replaces bits 33:18 and keeps bits 35:34 and 17:0.
- R10: A byte write replaces only the 8 bits of its lane (positions as in R6) with `elem_wdata[7:0]` and keeps the other 28 bits.
- R11: Each element takes two cycles: a memory read in `ST_XLATE`, then in `ST_DATA` either a read element or a write to the same address. `done` rises one cycle after the last element, or one cycle after a failed translation, and the block is idle on the next cycle.
- R12: `done` is a one-cycle pulse. `tmo` is high only with `done` and only for a stopped transfer, and `resid` is 0 after a complete transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| map_we | input | 1 | Write the map entry at `map_idx` |
| map_idx | input | IDX_W | Map entry index for write and read-back |
| map_wvalid | input | 1 | Valid flag to write |
| map_wpfn | input | PFN_W | Page frame number to write |
| map_rvalid | output | 1 | Valid flag of entry `map_idx` |
| map_rpfn | output | PFN_W | Frame number of entry `map_idx` |
| req_valid | input | 1 | Start a transfer (taken when not busy) |
| req_addr | input | 18 | Unibus start byte address |
| req_count | input | CNT_W | Byte count |
| req_write | input | 1 | 1 = device to memory |
| req_byte | input | 1 | 1 = byte mode, 0 = 16-bit word mode |
| busy | output | 1 | Transfer in progress |
| elem_wdata | input | 16 | Write element data (byte mode uses bits 7:0) |
| elem_take | output | 1 | Write element consumed this cycle |
| elem_rvalid | output | 1 | Read element valid this cycle |
| elem_rdata | output | 16 | Read element data |
| mem_addr | output | PA_W | Memory word address |
| mem_rd | output | 1 | Memory read strobe, data next cycle |
| mem_rdata | input | 36 | Memory read data |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 36 | Memory write data |
| done | output | 1 | Transfer finished pulse |
| resid | output | CNT_W | Bytes not transferred, valid with `done` |
| tmo | output | 1 | Transfer stopped on a translation or memory failure, valid with `done` |

## Verification
The bench builds the block with `MAP_DEPTH=8`, `PAGE_OFF_W=2`, `PA_W=6` and `MEM_WORDS=20`. With these values a page covers sixteen bytes, so short transfers cross pages and reach an invalid entry partway through. Byte address 128 already lies past the table. Any frame number of 5 or more points beyond installed memory, which makes the nonexistent-memory stop reachable. Because the table is small, an address with bit 17 set also has a page index past the table, so those two failure causes are exercised together rather than apart.

// File: rtl/ubm_pkg.sv
package ubm_pkg;

    localparam int UB_AW  = 18;
    localparam int WORD_W = 36;
    localparam int HALF_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XLATE,
        ST_DATA,
        ST_DONE
    } ubm_state_e;

    // Bit position of the byte selected by the low two address bits.
    function automatic int unsigned lane_shift(input logic [1:0] lane);
        unique case (lane)
            2'd0: return 18;
            2'd1: return 26;
            2'd2: return 0;
            default: return 8;
        endcase
    endfunction

endpackage

// File: rtl/ubm_map_table.sv
module ubm_map_table #(
    parameter int DEPTH = 64,
    parameter int IDX_W = 6,
    parameter int PFN_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic             wvalid,
    input  logic [PFN_W-1:0] wpfn,
    output logic             rvalid,
    output logic [PFN_W-1:0] rpfn,
    input  logic [IDX_W-1:0] lk_idx,
    output logic             lk_valid,
    output logic [PFN_W-1:0] lk_pfn
);

    logic             valid_q [DEPTH];
    logic [PFN_W-1:0] pfn_q   [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst) begin
                valid_q[i] <= 1'b0;
            end else if (we && (int'(idx) == i)) begin
                valid_q[i] <= wvalid;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (we && (int'(idx) == i)) begin
                pfn_q[i] <= wpfn;
            end
        end
    end

    always_comb begin
        rvalid   = 1'b0;
        rpfn     = '0;
        lk_valid = 1'b0;
        lk_pfn   = '0;
        if (int'(idx) < DEPTH) begin
            rvalid = valid_q[idx];
            rpfn   = pfn_q[idx];
        end
        if (int'(lk_idx) < DEPTH) begin
            lk_valid = valid_q[lk_idx];
            lk_pfn   = pfn_q[lk_idx];
        end
    end

endmodule

// File: rtl/ubm_lane_pack.sv
module ubm_lane_pack
    import ubm_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [1:0]        lane,
    input  logic              is_byte,
    input  logic [HALF_W-1:0] wdata,
    output logic [HALF_W-1:0] rdata,
    output logic [WORD_W-1:0] merged
);

    int unsigned sh;

    always_comb begin
        sh = lane_shift(lane);
        if (is_byte) begin
            rdata  = {8'h00, 8'(word >> sh)};
            merged = (word & ~(36'hFF << sh)) | (36'(wdata[7:0]) << sh);
        end else if (lane[1]) begin
            rdata  = word[15:0];
            merged = {word[35:16], wdata};
        end else begin
            rdata  = word[33:18];
            merged = {word[35:34], wdata, word[17:0]};
        end
    end

endmodule

// File: rtl/ubm_dma_map.sv
module ubm_dma_map
    import ubm_pkg::*;
#(
    parameter int MAP_DEPTH  = 64,
    parameter int PAGE_OFF_W = 9,
    parameter int PA_W       = 22,
    parameter int MEM_WORDS  = 262144,
    parameter int CNT_W      = 18,
    localparam int IDX_W     = $clog2(MAP_DEPTH),
    localparam int PFN_W     = PA_W - PAGE_OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              map_we,
    input  logic [IDX_W-1:0]  map_idx,
    input  logic              map_wvalid,
    input  logic [PFN_W-1:0]  map_wpfn,
    output logic              map_rvalid,
    output logic [PFN_W-1:0]  map_rpfn,
    input  logic              req_valid,
    input  logic [17:0]       req_addr,
    input  logic [CNT_W-1:0]  req_count,
    input  logic              req_write,
    input  logic              req_byte,
    output logic              busy,
    input  logic [15:0]       elem_wdata,
    output logic              elem_take,
    output logic              elem_rvalid,
    output logic [15:0]       elem_rdata,
    output logic [PA_W-1:0]   mem_addr,
    output logic              mem_rd,
    input  logic [35:0]       mem_rdata,
    output logic              mem_wr,
    output logic [35:0]       mem_wdata,
    output logic              done,
    output logic [CNT_W-1:0]  resid,
    output logic              tmo
);

    localparam int WA_W  = UB_AW - 2;
    localparam int VPN_W = WA_W - PAGE_OFF_W;

    ubm_state_e        state_q, state_d;
    logic [17:0]       addr_q;
    logic [CNT_W-1:0]  rem_q;
    logic              wr_q, byte_q, tmo_q;
    logic [PA_W-1:0]   pa_q;

    logic [WA_W-1:0]       wa;
    logic [VPN_W-1:0]      vpn;
    logic [PAGE_OFF_W-1:0] off;
    logic                  lk_valid, in_range, nxm, xl_ok;
    logic [PFN_W-1:0]      lk_pfn;
    logic [PA_W-1:0]       pa_c;
    logic [CNT_W-1:0]      step, count_eff;
    logic [15:0]           pk_rdata;
    logic [35:0]           pk_merged;

    ubm_map_table #(
        .DEPTH (MAP_DEPTH),
        .IDX_W (IDX_W),
        .PFN_W (PFN_W)
    ) u_table (
        .clk      (clk),
        .rst      (rst),
        .we       (map_we),
        .idx      (map_idx),
        .wvalid   (map_wvalid),
        .wpfn     (map_wpfn),
        .rvalid   (map_rvalid),
        .rpfn     (map_rpfn),
        .lk_idx   (IDX_W'(vpn)),
        .lk_valid (lk_valid),
        .lk_pfn   (lk_pfn)
    );

    ubm_lane_pack u_pack (
        .word    (mem_rdata),
        .lane    (addr_q[1:0]),
        .is_byte (byte_q),
        .wdata   (elem_wdata),
        .rdata   (pk_rdata),
        .merged  (pk_merged)
    );

    // Translation of the current element address
    always_comb begin
        wa       = addr_q[17:2];
        vpn      = wa[WA_W-1:PAGE_OFF_W];
        off      = wa[PAGE_OFF_W-1:0];
        in_range = 32'(vpn) < 32'(MAP_DEPTH);
        pa_c     = {lk_pfn, off};
        nxm      = 32'(pa_c) >= 32'(MEM_WORDS);
        xl_ok    = in_range && !addr_q[17] && lk_valid && !nxm;
        step     = byte_q ? CNT_W'(1) : CNT_W'(2);
        count_eff = req_byte ? req_count : {req_count[CNT_W-1:1], 1'b0};
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = (count_eff == '0) ? ST_DONE : ST_XLATE;
            ST_XLATE: state_d = xl_ok ? ST_DATA : ST_DONE;
            ST_DATA:  state_d = (rem_q == step) ? ST_DONE : ST_XLATE;
            ST_DONE:  state_d = ST_IDLE;
        endcase
    end

    // State register and datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            rem_q   <= '0;
            wr_q    <= 1'b0;
            byte_q  <= 1'b0;
            tmo_q   <= 1'b0;
            pa_q    <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q <= req_byte ? req_addr : {req_addr[17:1], 1'b0};
                        rem_q  <= count_eff;
                        wr_q   <= req_write;
                        byte_q <= req_byte;
                        tmo_q  <= 1'b0;
                    end
                end
                ST_XLATE: begin
                    pa_q <= pa_c;
                    if (!xl_ok) tmo_q <= 1'b1;
                end
                ST_DATA: begin
                    addr_q <= addr_q + (byte_q ? 18'd1 : 18'd2);
                    rem_q  <= rem_q - step;
                end
                ST_DONE: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy        = (state_q != ST_IDLE);
        mem_rd      = (state_q == ST_XLATE) && xl_ok;
        mem_addr    = (state_q == ST_XLATE) ? pa_c : pa_q;
        elem_rvalid = (state_q == ST_DATA) && !wr_q;
        elem_take   = (state_q == ST_DATA) && wr_q;
        elem_rdata  = pk_rdata;
        mem_wr      = elem_take;
        mem_wdata   = pk_merged;
        done        = (state_q == ST_DONE);
        resid       = done ? rem_q : '0;
        tmo         = done && tmo_q;
    end

endmodule

// File: rtl/ubm_dma_map_chk.sv
module ubm_dma_map_chk #(
    parameter int PA_W = 22
) (
    input logic            clk,
    input logic            rst,
    input logic            busy,
    input logic            done,
    input logic            tmo,
    input logic            mem_rd,
    input logic            mem_wr,
    input logic [PA_W-1:0] mem_addr,
    input logic [35:0]     mem_rdata,
    input logic [35:0]     mem_wdata,
    input logic            elem_rvalid,
    input logic            elem_take
);

    a_r11_wr_follows_rd: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> $past(mem_rd));

    a_r11_wr_same_addr: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> mem_addr == $past(mem_addr));

    a_r11_rd_then_elem: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> (elem_rvalid || elem_take));

    a_r11_rd_wr_excl: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    a_r11_done_to_idle: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    a_r12_tmo_with_done: assert property (@(posedge clk) disable iff (rst)
        tmo |-> done);

    a_r12_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r9_guard_bits_kept: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> mem_wdata[35:34] == mem_rdata[35:34]);

endmodule

bind ubm_dma_map ubm_dma_map_chk #(.PA_W(PA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .busy        (busy),
    .done        (done),
    .tmo         (tmo),
    .mem_rd      (mem_rd),
    .mem_wr      (mem_wr),
    .mem_addr    (mem_addr),
    .mem_rdata   (mem_rdata),
    .mem_wdata   (mem_wdata),
    .elem_rvalid (elem_rvalid),
    .elem_take   (elem_take)
);

// File: tb/test_ubm_dma_map.sv
`timescale 1ns/1ps
module test_ubm_dma_map;

    localparam int MD  = 8;
    localparam int POW = 2;
    localparam int PAW = 6;
    localparam int MW  = 20;
    localparam int CW  = 18;
    localparam int IW  = 3;
    localparam int FW  = PAW - POW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          map_we = 1'b0;
    logic [IW-1:0] map_idx = '0;
    logic          map_wvalid = 1'b0;
    logic [FW-1:0] map_wpfn = '0;
    logic          map_rvalid;
    logic [FW-1:0] map_rpfn;
    logic          req_valid = 1'b0;
    logic [17:0]   req_addr = '0;
    logic [CW-1:0] req_count = '0;
    logic          req_write = 1'b0;
    logic          req_byte = 1'b0;
    logic          busy;
    logic [15:0]   elem_wdata = '0;
    logic          elem_take, elem_rvalid;
    logic [15:0]   elem_rdata;
    logic [PAW-1:0] mem_addr;
    logic          mem_rd, mem_wr;
    logic [35:0]   mem_rdata = '0;
    logic [35:0]   mem_wdata;
    logic          done;
    logic [CW-1:0] resid;
    logic          tmo;

    always #5 clk = ~clk;

    ubm_dma_map #(
        .MAP_DEPTH  (MD),
        .PAGE_OFF_W (POW),
        .PA_W       (PAW),
        .MEM_WORDS  (MW),
        .CNT_W      (CW)
    ) i_ubm_dma_map (
        .clk, .rst, .map_we, .map_idx, .map_wvalid, .map_wpfn, .map_rvalid, .map_rpfn,
        .req_valid, .req_addr, .req_count, .req_write, .req_byte, .busy,
        .elem_wdata, .elem_take, .elem_rvalid, .elem_rdata,
        .mem_addr, .mem_rd, .mem_rdata, .mem_wr, .mem_wdata,
        .done, .resid, .tmo
    );

    // External memory model and its expected image
    logic [35:0] mem  [MW];
    logic [35:0] shad [MW];
    bit          sh_v   [MD];
    int          sh_pfn [MD];

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= (int'(mem_addr) < MW) ? mem[mem_addr] : 36'h0;
        if (mem_wr && int'(mem_addr) < MW) mem[mem_addr] <= mem_wdata;
    end

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // Scoreboard state
    logic [15:0] rq[$];
    logic [15:0] wbuf[$];
    int    wd_idx = 0;
    bit    take_d = 1'b0;
    int    n_rd = 0;
    int    n_wr = 0;
    string cur_tag = "R6";

    always @(negedge clk) begin
        if (take_d) begin
            wd_idx++;
            if (wd_idx < wbuf.size()) elem_wdata = wbuf[wd_idx];
        end
        take_d = elem_take;
        if (mem_rd) n_rd++;
        if (mem_wr) n_wr++;
        if (elem_rvalid) begin
            if (rq.size() == 0) begin
                chk(1'b0, cur_tag, 64'(elem_rdata), 64'h0);
            end else begin
                logic [15:0] e;
                e = rq.pop_front();
                chk(elem_rdata == e, cur_tag, 64'(elem_rdata), 64'(e));
            end
        end
    end

    // R3/R4/R5 translation as the requirements define it
    function automatic bit xl(input logic [17:0] ba, output int pa);
        int wa, vpn;
        wa  = int'(ba) >> 2;
        vpn = wa >> POW;
        pa  = 0;
        if (vpn >= MD || ba[17] || !sh_v[vpn]) return 1'b0;
        pa = sh_pfn[vpn] * (1 << POW) + (wa % (1 << POW));
        return pa < MW;
    endfunction

    function automatic int lsh(input logic [1:0] l);
        case (l)
            2'd0: return 18;
            2'd1: return 26;
            2'd2: return 0;
            default: return 8;
        endcase
    endfunction

    // R6/R7 extraction
    function automatic logic [15:0] ext(input logic [35:0] w, input logic [17:0] ba, input bit byt);
        if (byt) return {8'h00, 8'(w >> lsh(ba[1:0]))};
        if (ba[1]) return w[15:0];
        return w[33:18];
    endfunction

    // R9/R10 merge
    function automatic logic [35:0] mrg(input logic [35:0] w, input logic [17:0] ba, input bit byt,
                                        input logic [15:0] d);
        logic [35:0] r;
        r = w;
        if (byt) begin
            for (int b = 0; b < 8; b++) r[lsh(ba[1:0]) + b] = d[b];
        end else if (ba[1]) begin
            r[15:0] = d;
        end else begin
            r[33:18] = d;
        end
        return r;
    endfunction

    task automatic map_set(input int idx, input bit v, input int pfn);
        @(negedge clk);
        map_we = 1'b1; map_idx = IW'(idx); map_wvalid = v; map_wpfn = FW'(pfn);
        @(negedge clk);
        map_we = 1'b0;
        sh_v[idx] = v; sh_pfn[idx] = pfn;
    endtask

    task automatic map_chk(input int idx);
        @(negedge clk);
        map_idx = IW'(idx);
        @(negedge clk);
        chk(map_rvalid == sh_v[idx], "R2", 64'(map_rvalid), 64'(sh_v[idx]));
        if (sh_v[idx]) chk(int'(map_rpfn) == sh_pfn[idx], "R2", 64'(map_rpfn), 64'(sh_pfn[idx]));
    endtask

    // Driver: computes expected elements, pushes them, runs one transfer, checks the outcome
    task automatic run(input logic [17:0] ba, input int cnt, input bit wr, input bit byt, input string tag);
        logic [17:0] a;
        int rem, n, pa, stp, exp_cyc, cyc;
        bit ok;
        logic [15:0] d;
        cur_tag = tag;
        a   = byt ? ba : {ba[17:1], 1'b0};
        rem = byt ? cnt : (cnt & ~1);
        stp = byt ? 1 : 2;
        n = 0; ok = 1'b1;
        wbuf.delete();
        while (rem > 0) begin
            if (!xl(a, pa)) begin ok = 1'b0; break; end
            if (wr) begin
                d = 16'hA5C3 ^ (16'(n) * 16'h1357);
                if (byt) d = {8'h00, d[7:0]};
                wbuf.push_back(d);
                shad[pa] = mrg(shad[pa], a, byt, d);
            end else begin
                rq.push_back(ext(shad[pa], a, byt));
            end
            a = a + 18'(stp);
            rem -= stp;
            n++;
        end
        exp_cyc = ok ? 2 * n + 1 : 2 * n + 2;
        @(negedge clk);
        wd_idx = 0;
        elem_wdata = (wbuf.size() > 0) ? wbuf[0] : 16'h0;
        n_rd = 0; n_wr = 0;
        req_valid = 1'b1; req_addr = ba; req_count = CW'(cnt); req_write = wr; req_byte = byt;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1;
        while (!done && cyc < 60) begin
            @(negedge clk);
            cyc++;
        end
        chk(done, "R12", 64'(done), 64'h1);
        chk(cyc == exp_cyc, "R11", 64'(cyc), 64'(exp_cyc));
        chk(int'(resid) == rem, ok ? "R12" : tag, 64'(resid), 64'(rem));
        chk(tmo == !ok, ok ? "R12" : tag, 64'(tmo), 64'(!ok));
        chk(n_rd == n, "R11", 64'(n_rd), 64'(n));
        chk(n_wr == (wr ? n : 0), "R11", 64'(n_wr), 64'(wr ? n : 0));
        chk(rq.size() == 0, tag, 64'(rq.size()), 64'h0);
        rq.delete();
        for (int i = 0; i < MW; i++) begin
            if (mem[i] !== shad[i]) chk(1'b0, tag, 64'(mem[i]), 64'(shad[i]));
        end
        chk(1'b1, tag, 64'h0, 64'h0);
        @(negedge clk);
        chk(!busy && !done, "R11", 64'({busy, done}), 64'h0);
    endtask

    initial begin
        for (int i = 0; i < MW; i++) begin
            mem[i]  = 36'h9_1234_5678 ^ (36'(i) * 36'h1_0F3C_5A97);
            shad[i] = mem[i];
        end
        for (int i = 0; i < MD; i++) begin
            sh_v[i] = 1'b0; sh_pfn[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(!busy && !done, "R1", 64'({busy, done}), 64'h0);
        map_chk(0);
        map_chk(5);
        run(18'd0, 4, 1'b0, 1'b1, "R1");

        // R2: program the table
        map_set(0, 1'b1, 1);
        map_set(1, 1'b1, 2);
        map_set(3, 1'b1, 6);
        map_chk(0);
        map_chk(1);
        map_chk(2);
        map_chk(3);

        run(18'd0, 8, 1'b0, 1'b1, "R6");      // R3, all four byte lanes over two words
        run(18'd17, 7, 1'b0, 1'b0, "R7");     // R8 alignment, page 1 halves
        run(18'd9, 1, 1'b0, 1'b0, "R8");      // zero effective count
        run(18'd2, 4, 1'b1, 1'b0, "R9");      // low then high half
        run(18'd20, 6, 1'b1, 1'b0, "R9");     // R3 page 1, across words
        run(18'd5, 3, 1'b1, 1'b1, "R10");     // byte writes lanes 1..3
        run(18'd4, 4, 1'b0, 1'b1, "R10");     // read back after byte writes
        run(18'd32, 5, 1'b0, 1'b1, "R4");     // invalid entry
        run(18'd28, 8, 1'b0, 1'b1, "R4");     // stop partway at page boundary
        run(18'd128, 4, 1'b0, 1'b1, "R4");    // page index past table
        run(18'o400004, 4, 1'b0, 1'b0, "R4"); // address bit 17 set
        run(18'd48, 2, 1'b0, 1'b0, "R5");     // nonexistent memory
        map_set(0, 1'b0, 1);
        map_chk(0);
        run(18'd0, 2, 1'b1, 1'b0, "R2");      // entry cleared makes translation fail

        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule